// File: doc/BRIEF.md
# Byte-wide SPI transceiver (master or slave)

This block is a full-duplex serial engine that moves one byte out and one byte in per transfer. It has a small register port with three registers: control, status and data. A write to the data register starts a transfer. Reading the data register returns the byte that was last received. Bits leave and arrive most significant first.

As master, the block makes the serial clock from the system clock with a power-of-two divider. As slave, it follows a serial clock from the pin. In slave mode an active-low select can gate the transfer, so that clock edges count only while the select is low. At the end of each transfer the block sets a completion flag, which can drive an interrupt. The block also flags a receive overflow: a new byte arrived while the previous one had not been read.

Top module: `spi_xcvr`

Register port: address 0 is control, address 1 is status, address 2 is data.

- Control bits: [7] edge select, [6] interrupt enable, [5] master role (1 = master), [4] slave-select gating enable, [3] reserved (reads 0), [2:0] baud select.
- Status bits: [0] busy, [1] completion flag, [2] overflow flag. Writing 1 to bit 1 or bit 2 clears that flag. All other status bits read 0.

## Requirements
- R1: After reset, control, status and receive data all read 0, and sck_o, sdo and irq are all 0.
- R2: In master mode, a write to the data register while idle sets busy and starts a transfer. sck_o then gives 8 pulses, and every high or low phase lasts 2^baud system clocks. sck_o stays low whenever the block is not busy.
- R3: A transfer sends the written byte on sdo and assembles the byte from sdi. Both go most significant bit first. The received byte reads back at address 2.
- R4: With edge select 0, sdi is sampled on rising SCK and sdo changes after falling SCK. With edge select 1, sdi is sampled on falling SCK and sdo changes after rising SCK. The first SCK edge never moves sdo.
- R5: In slave mode, shifting follows sck_i, which is synchronised in the block. The transfer ends, and busy clears, after the eighth sampling edge.
- R6: In slave mode with gating enabled, sck_i edges have no effect while ss_n_i is high.
- R7: Completion sets status bit 1. irq equals that bit AND interrupt enable. If completion and a software clear of bit 1 fall in the same cycle, the flag stays set.
- R8: A write to the data register while busy is ignored, and the transfer in flight keeps its byte.
- R9: If a transfer completes while the previous received byte is still unread, status bit 2 is set. A read of address 2 with reg_re marks the byte as read. Writing 1 to status bit 2 clears the flag.
- R10: The receive data register changes only when a transfer completes. A read during a transfer returns the previous byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (marks receive data as read) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data (combinational) |
| irq | output | 1 | Completion interrupt |
| sck_i | input | 1 | Serial clock from the pin (slave) |
| sck_o | output | 1 | Serial clock to the pin (master) |
| ss_n_i | input | 1 | Active-low slave select |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |

## Verification
The completion flag can be set by hardware in the same cycle that software clears it. The bench provokes this by holding a clear write to status bit 1 on every cycle of a master transfer, so the collision cannot be missed. It then requires irq to be seen high for exactly one cycle. A design in which the clear wins shows zero such cycles. A design that ignores the clear shows a flag that stays high.

// File: rtl/spi_xcvr_pkg.sv
package spi_xcvr_pkg;
  localparam int BAUD_W = 3;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  typedef struct packed {
    logic              edge_sel;
    logic              irq_en;
    logic              master;
    logic              ss_en;
    logic              rsv;
    logic [BAUD_W-1:0] baud;
  } ctrl_t;
endpackage

// File: rtl/spi_xcvr_regs.sv
module spi_xcvr_regs
  import spi_xcvr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              re,
  input  logic [1:0]        addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic              busy,
  input  logic              complete,
  input  logic [DW-1:0]     rx_word,
  output logic              tx_load,
  output logic [DW-1:0]     tx_word,
  output logic              edge_sel,
  output logic              master,
  output logic              ss_en,
  output logic [BAUD_W-1:0] baud,
  output logic              irq
);
  ctrl_t         ctrl_q, ctrl_n;
  logic [DW-1:0] rxbuf_q, rxbuf_n;
  logic          done_q, done_n;
  logic          ovf_q, ovf_n;
  logic          unread_q, unread_n;
  logic          wr_ctrl, wr_stat, wr_data, rd_data;

  assign wr_ctrl = we && (addr == ADDR_CTRL);
  assign wr_stat = we && (addr == ADDR_STAT);
  assign wr_data = we && (addr == ADDR_DATA);
  assign rd_data = re && (addr == ADDR_DATA);

  assign tx_load  = wr_data && !busy;
  assign tx_word  = wdata;
  assign edge_sel = ctrl_q.edge_sel;
  assign master   = ctrl_q.master;
  assign ss_en    = ctrl_q.ss_en;
  assign baud     = ctrl_q.baud;
  assign irq      = done_q && ctrl_q.irq_en;

  always_comb begin
    ctrl_n   = ctrl_q;
    rxbuf_n  = rxbuf_q;
    done_n   = done_q;
    ovf_n    = ovf_q;
    unread_n = unread_q;
    if (wr_ctrl) begin
      ctrl_n     = ctrl_t'(wdata[7:0]);
      ctrl_n.rsv = 1'b0;
    end
    if (wr_stat && wdata[1]) done_n = 1'b0;
    if (wr_stat && wdata[2]) ovf_n  = 1'b0;
    if (rd_data) unread_n = 1'b0;
    if (complete) begin
      done_n   = 1'b1;
      unread_n = 1'b1;
      rxbuf_n  = rx_word;
      if (unread_q && !rd_data) ovf_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      rxbuf_q  <= '0;
      done_q   <= 1'b0;
      ovf_q    <= 1'b0;
      unread_q <= 1'b0;
    end else begin
      ctrl_q   <= ctrl_n;
      rxbuf_q  <= rxbuf_n;
      done_q   <= done_n;
      ovf_q    <= ovf_n;
      unread_q <= unread_n;
    end
  end

  always_comb begin
    case (addr)
      ADDR_CTRL: rdata = DW'(ctrl_q);
      ADDR_STAT: rdata = DW'({ovf_q, done_q, busy});
      ADDR_DATA: rdata = rxbuf_q;
      default:   rdata = '0;
    endcase
  end

  // R7: hardware set wins over a software clear in the same cycle
  a_r7_done_set: assert property (@(posedge clk) disable iff (!rst_n)
    complete |=> done_q);
  // R9: completion over an unread byte raises overflow
  a_r9_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
    (complete && unread_q && !rd_data) |=> ovf_q);
  // R10: receive data only moves on completion
  a_r10_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !complete |=> $stable(rxbuf_q));
endmodule

// File: rtl/spi_xcvr_clk.sv
module spi_xcvr_clk
  import spi_xcvr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master,
  input  logic              ss_en,
  input  logic [BAUD_W-1:0] baud,
  input  logic              start,
  input  logic              run,
  input  logic              sck_i,
  input  logic              ss_n_i,
  input  logic              sdi,
  output logic              sck_o,
  output logic              rise,
  output logic              fall,
  output logic              sdi_bit,
  output logic              m_end
);
  localparam int DIV_W = (1 << BAUD_W) - 1;
  localparam int TOG_W = $clog2(2*DW+1);

  logic [DIV_W-1:0] div_q, div_n;
  logic [TOG_W-1:0] tog_q, tog_n;
  logic             sck_q, sck_n;
  logic [DIV_W:0]   half;
  logic             tick, m_rise, m_fall;
  logic [2:0]       sck_sy;
  logic [1:0]       sdi_sy, ss_sy;
  logic             s_rise, s_fall, gate_open;

  // master clock generator
  assign half   = (DIV_W+1)'(1) << baud;
  assign tick   = master && run && ({1'b0, div_q} == half - 1'b1);
  assign m_rise = tick && !sck_q;
  assign m_fall = tick && sck_q;
  assign m_end  = tick && (tog_q == TOG_W'(2*DW-1));
  assign sck_o  = sck_q;

  always_comb begin
    div_n = div_q;
    tog_n = tog_q;
    sck_n = sck_q;
    if (start) begin
      div_n = '0;
      tog_n = '0;
      sck_n = 1'b0;
    end else if (master && run) begin
      if (tick) begin
        div_n = '0;
        sck_n = ~sck_q;
        tog_n = tog_q + 1'b1;
      end else begin
        div_n = div_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      tog_q <= '0;
      sck_q <= 1'b0;
    end else begin
      div_q <= div_n;
      tog_q <= tog_n;
      sck_q <= sck_n;
    end
  end

  // slave input synchronisers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sy <= '0;
      sdi_sy <= '0;
      ss_sy  <= '1;
    end else begin
      sck_sy <= {sck_sy[1:0], sck_i};
      sdi_sy <= {sdi_sy[0], sdi};
      ss_sy  <= {ss_sy[0], ss_n_i};
    end
  end

  assign s_rise    = sck_sy[1] && !sck_sy[2];
  assign s_fall    = !sck_sy[1] && sck_sy[2];
  assign gate_open = !ss_en || !ss_sy[1];

  assign rise    = master ? m_rise : (run && gate_open && s_rise);
  assign fall    = master ? m_fall : (run && gate_open && s_fall);
  assign sdi_bit = master ? sdi : sdi_sy[1];

  // R2: serial clock idles low
  a_r2_sck_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !sck_q);
  // R6: gated slave sees no edges while select is high
  a_r6_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (!master && ss_en && ss_sy[1]) |-> !(rise || fall));
endmodule

// File: rtl/spi_xcvr_shift.sv
module spi_xcvr_shift #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] tx_word,
  input  logic          edge_sel,
  input  logic          master,
  input  logic          rise,
  input  logic          fall,
  input  logic          sdi_bit,
  input  logic          m_end,
  output logic          run,
  output logic          sdo,
  output logic          complete,
  output logic [DW-1:0] rx_word
);
  localparam int CNT_W = $clog2(DW+1);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [DW-1:0]    tx_q, tx_n, rx_q, rx_n;
  logic             run_q, run_n;
  logic             sample, shift, take;

  assign sample   = edge_sel ? fall : rise;
  assign shift    = edge_sel ? rise : fall;
  assign take     = run_q && sample && (cnt_q < CNT_W'(DW));
  assign complete = run_q && (master ? m_end : (take && cnt_q == CNT_W'(DW-1)));
  assign rx_word  = take ? {rx_q[DW-2:0], sdi_bit} : rx_q;
  assign run      = run_q;
  assign sdo      = tx_q[DW-1];

  always_comb begin
    cnt_n = cnt_q;
    tx_n  = tx_q;
    rx_n  = rx_q;
    run_n = run_q;
    if (start) begin
      run_n = 1'b1;
      tx_n  = tx_word;
      rx_n  = '0;
      cnt_n = '0;
    end else if (run_q) begin
      if (take) begin
        rx_n  = {rx_q[DW-2:0], sdi_bit};
        cnt_n = cnt_q + 1'b1;
      end
      if (shift && cnt_q != '0) tx_n = {tx_q[DW-2:0], 1'b0};
      if (complete) run_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tx_q  <= '0;
      rx_q  <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      tx_q  <= tx_n;
      rx_q  <= rx_n;
      run_q <= run_n;
    end
  end

  // R8: no new load is accepted while a transfer runs
  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> !start);
  // R5/R10: a transfer ends only with a full byte taken
  a_r10_full_byte: assert property (@(posedge clk) disable iff (!rst_n)
    complete |-> (cnt_q == CNT_W'(DW) || (take && cnt_q == CNT_W'(DW-1))));
endmodule

// File: rtl/spi_xcvr.sv
module spi_xcvr
  import spi_xcvr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic          reg_re,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq,
  input  logic          sck_i,
  output logic          sck_o,
  input  logic          ss_n_i,
  input  logic          sdi,
  output logic          sdo
);
  logic [1:0]        rst_sy;
  logic              rst_ni;
  logic              run, complete, tx_load;
  logic [DW-1:0]     rx_word, tx_word;
  logic              edge_sel, master, ss_en;
  logic [BAUD_W-1:0] baud;
  logic              rise, fall, sdi_bit, m_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sy <= '0;
    else        rst_sy <= {rst_sy[0], 1'b1};
  end
  assign rst_ni = rst_sy[1];

  spi_xcvr_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_ni), .we(reg_we), .re(reg_re), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .busy(run), .complete(complete),
    .rx_word(rx_word), .tx_load(tx_load), .tx_word(tx_word),
    .edge_sel(edge_sel), .master(master), .ss_en(ss_en), .baud(baud), .irq(irq)
  );

  spi_xcvr_clk #(.DW(DW)) u_clk (
    .clk(clk), .rst_n(rst_ni), .master(master), .ss_en(ss_en), .baud(baud),
    .start(tx_load), .run(run), .sck_i(sck_i), .ss_n_i(ss_n_i), .sdi(sdi),
    .sck_o(sck_o), .rise(rise), .fall(fall), .sdi_bit(sdi_bit), .m_end(m_end)
  );

  spi_xcvr_shift #(.DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_ni), .start(tx_load), .tx_word(tx_word),
    .edge_sel(edge_sel), .master(master), .rise(rise), .fall(fall),
    .sdi_bit(sdi_bit), .m_end(m_end), .run(run), .sdo(sdo),
    .complete(complete), .rx_word(rx_word)
  );
endmodule

// File: tb/test_spi_xcvr.sv
module test_spi_xcvr;
  localparam int DW = 8;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, reg_we, reg_re, sck_i, ss_n_i, sdi;
  logic [1:0] reg_addr;
  logic [DW-1:0] reg_wdata, reg_rdata;
  logic irq, sck_o, sdo;

  spi_xcvr #(.DW(DW)) i_spi_xcvr (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .sck_i(sck_i), .sck_o(sck_o), .ss_n_i(ss_n_i),
    .sdi(sdi), .sdo(sdo)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  bit finished = 0;

  // behavioural model of the far end of a master transfer
  bit m_active = 0, m_es = 0, have_prev = 0;
  int exp_half = 1, last_tog = 0, togs = 0, pi = 0, ci = 0, irq_seen = 0;
  logic [7:0] m_din = 0, m_dout = 0;
  logic sck_prev = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (irq === 1'b1) irq_seen++;
    if (sck_o !== sck_prev) begin
      if (!m_active) chk(0, "R2 sck_o moved while idle", sck_o, 0);
      else begin
        if (have_prev) chk(cyc - last_tog == exp_half, "R2 phase length", cyc - last_tog, exp_half);
        have_prev = 1; last_tog = cyc; togs++;
        if (sck_o == m_es) begin
          if (pi >= 0) begin sdi = m_din[pi]; pi--; end
        end else begin
          if (ci >= 0) begin m_dout[ci] = sdo; ci--; end
        end
        if (togs == 16) m_active = 0;
      end
      sck_prev = sck_o;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); reg_addr = a; reg_re = 1; #1 v = reg_rdata;
    @(negedge clk); reg_re = 0;
  endtask

  task automatic master_xfer(input logic [7:0] tx, input logic [7:0] din, input logic es,
                             input int baud, input bit intr, input logic [7:0] old_rx, input bit hold_clr);
    logic [7:0] v;
    m_din = din; m_es = es; exp_half = 1 << baud; have_prev = 0; togs = 0; m_dout = 0; ci = 7;
    if (!es) begin sdi = din[7]; pi = 6; end else pi = 7;
    m_active = 1;
    wr(2'd2, tx);
    if (hold_clr) begin reg_we = 1; reg_addr = 2'd1; reg_wdata = 8'h02; end
    if (intr) begin
      while (togs < 4) @(negedge clk);
      rd(2'd2, v); chk(v == old_rx, "R10 rx during transfer", v, old_rx);
      rd(2'd1, v); chk(v[0] == 1'b1, "R2 busy during transfer", v[0], 1);
      wr(2'd2, 8'h3C);
    end
    while (m_active) @(negedge clk);
    repeat (3) @(negedge clk);
    if (hold_clr) reg_we = 0;
  endtask

  task automatic slave_bits(input logic [7:0] din, input logic es, output logic [7:0] dout);
    for (int i = 7; i >= 0; i--) begin
      if (!es) begin
        sdi = din[i]; repeat (8) @(negedge clk); dout[i] = sdo;
        sck_i = 1; repeat (8) @(negedge clk); sck_i = 0;
      end else begin
        sck_i = 1; sdi = din[i]; repeat (8) @(negedge clk); dout[i] = sdo;
        sck_i = 0; repeat (8) @(negedge clk);
      end
    end
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      chk(0, "watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, d;
    rst_n = 0; reg_we = 0; reg_re = 0; reg_addr = 0; reg_wdata = 0;
    sck_i = 0; ss_n_i = 1; sdi = 0;
    repeat (4) @(negedge clk); rst_n = 1; repeat (3) @(negedge clk);

    // R1 reset state
    rd(2'd0, v); chk(v == 0, "R1 control after reset", v, 0);
    rd(2'd1, v); chk(v == 0, "R1 status after reset", v, 0);
    rd(2'd2, v); chk(v == 0, "R1 rx after reset", v, 0);
    chk({sck_o, sdo, irq} == 0, "R1 outputs after reset", {sck_o, sdo, irq}, 0);

    // R2 R3 R4: master, edge 0, fastest clock, irq disabled
    wr(2'd0, 8'b0010_0000);
    master_xfer(8'hA5, 8'h3C, 1'b0, 0, 0, 8'h00, 0);
    chk(m_dout == 8'hA5, "R3 sdo byte (edge 0)", m_dout, 8'hA5);
    rd(2'd1, v); chk(v == 8'h02, "R7 status after completion", v, 8'h02);
    chk(irq == 0, "R7 irq masked", irq, 0);
    rd(2'd2, v); chk(v == 8'h3C, "R3 rx byte (edge 0)", v, 8'h3C);
    wr(2'd1, 8'h02);
    rd(2'd1, v); chk(v == 8'h00, "R7 flag cleared", v, 0);

    // R4: edge 1, divide by 8
    wr(2'd0, 8'b1010_0010);
    master_xfer(8'h96, 8'h5B, 1'b1, 2, 0, 8'h00, 0);
    chk(m_dout == 8'h96, "R4 sdo byte (edge 1)", m_dout, 8'h96);
    rd(2'd2, v); chk(v == 8'h5B, "R4 rx byte (edge 1)", v, 8'h5B);

    // R8 R10: ignored write and stale read mid-transfer
    wr(2'd0, 8'b0010_0011);
    master_xfer(8'hC3, 8'h81, 1'b0, 3, 1, 8'h5B, 0);
    chk(m_dout == 8'hC3, "R8 byte kept after busy write", m_dout, 8'hC3);
    rd(2'd2, v); chk(v == 8'h81, "R8 rx after busy write", v, 8'h81);

    // R7: completion collides with a held clear
    wr(2'd1, 8'h06);
    wr(2'd0, 8'b0110_0000);
    irq_seen = 0;
    master_xfer(8'h0F, 8'hF0, 1'b0, 0, 0, 8'h00, 1);
    chk(irq_seen == 1, "R7 set wins over clear", irq_seen, 1);
    rd(2'd1, v); chk(v[1] == 1'b0, "R7 flag cleared after hold", v[1], 0);
    rd(2'd2, v); chk(v == 8'hF0, "R3 rx byte (collision run)", v, 8'hF0);

    // R5: slave, edge 0
    wr(2'd0, 8'b0000_0000);
    wr(2'd2, 8'h69); repeat (4) @(negedge clk);
    slave_bits(8'hE4, 1'b0, d);
    chk(d == 8'h69, "R5 slave sdo byte", d, 8'h69);
    rd(2'd1, v); chk(v == 8'h02, "R5 slave done, not busy", v, 8'h02);
    rd(2'd2, v); chk(v == 8'hE4, "R5 slave rx byte", v, 8'hE4);

    // R9: overflow with slave, edge 1
    wr(2'd1, 8'h06);
    wr(2'd0, 8'b1000_0000);
    wr(2'd2, 8'h12); repeat (4) @(negedge clk);
    slave_bits(8'hF0, 1'b1, d);
    chk(d == 8'h12, "R4 slave edge 1 sdo", d, 8'h12);
    rd(2'd1, v); chk(v[2] == 1'b0, "R9 no overflow on first", v[2], 0);
    wr(2'd2, 8'h34); repeat (4) @(negedge clk);
    slave_bits(8'h0F, 1'b1, d);
    rd(2'd1, v); chk(v == 8'h06, "R9 overflow set", v, 8'h06);
    rd(2'd2, v); chk(v == 8'h0F, "R9 newest byte kept", v, 8'h0F);
    wr(2'd1, 8'h04);
    rd(2'd1, v); chk(v[2] == 1'b0, "R9 overflow cleared", v[2], 0);

    // R6: gated slave ignores edges while select high
    wr(2'd1, 8'h06);
    wr(2'd0, 8'b0001_0000);
    wr(2'd2, 8'hB7); repeat (4) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      sdi = 1; sck_i = 1; repeat (8) @(negedge clk); sck_i = 0; repeat (8) @(negedge clk);
    end
    rd(2'd1, v); chk(v == 8'h01, "R6 still busy, nothing done", v, 8'h01);
    chk(sdo == 1'b1, "R6 sdo unshifted", sdo, 1);
    ss_n_i = 0; repeat (4) @(negedge clk);
    slave_bits(8'h4D, 1'b0, d);
    ss_n_i = 1;
    chk(d == 8'hB7, "R6 sdo byte after gate", d, 8'hB7);
    rd(2'd2, v); chk(v == 8'h4D, "R6 rx byte after gate", v, 8'h4D);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule